// File: doc/BRIEF.md
# Eight-Line Write Cache with Page Flush Sequencer

This block sits between a serial bus front-end and a nonvolatile storage array. After a start address is loaded, incoming write bytes are collected in a 64-byte cache organised as eight lines of eight bytes. The first byte goes to the cache slot given by the low three address bits. Each later byte takes the next slot, and the pointer moves on into the following cache line when a line fills. Each cached byte carries a valid flag that records whether it was written since the last flush.

A commit pulse starts the flush. Cache line k is written to the array page that lies k pages after the page holding the start address, so the flush walks through consecutive pages and carries into the next row after the last page of a row. Each page write is a single-cycle strobe carrying row, page, eight data bytes and eight byte enables. A self-timed write cycle of `WCYC` clock cycles follows each strobe. Lines with no valid byte are skipped. The busy flag stays high from the commit until the flush is done, and while it is high the block ignores byte strobes, address loads and further commits.

Top module: `wcache_top`

## Requirements
- R1: After reset, `busy` and `pg_we` are 0, and the cache holds no valid byte.
- R2: The first byte after an address load is stored at cache line 0, byte slot `addr_in[2:0]`. The first page write targets row `addr_in[12:6]` and page `addr_in[5:3]`. In that write, byte slot i is carried on `pg_data[8i+7:8i]` with enable `pg_be[i]`.
- R3: Consecutive bytes fill consecutive slots. After slot 7 of a line, the next byte goes to slot 0 of the next cache line, and that line is written to the next array page.
- R4: Page targets for cache lines count up across the row boundary. The page after page 7 of row n is page 0 of row n+1.
- R5: After 64 bytes the pointer wraps to cache slot 0, and later bytes overwrite the bytes captured earlier.
- R6: `pg_be` is set only for slots loaded since the last flush, and all valid flags clear when the flush ends.
- R7: Each page write (`pg_we` high for one cycle) is followed by `WCYC` wait cycles before the next cache line is examined. A flush of eight full lines keeps `busy` high for exactly 8*(WCYC+1) cycles, starting in the cycle after the commit.
- R8: While `busy` is high, byte strobes, address loads and commits are ignored.
- R9: A commit while the cache holds no valid byte issues no page write and leaves `busy` at 0.
- R10: A cache line with no valid byte produces no page write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Load start address |
| addr_in | input | 13 | Start word address (row, page, byte) |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to cache |
| commit | input | 1 | Start flush of the cache to the array |
| pg_we | output | 1 | One-cycle page write strobe |
| pg_row | output | 7 | Target array row |
| pg_page | output | 3 | Target page within row |
| pg_data | output | 64 | Eight page bytes, slot i at bits 8i+7:8i |
| pg_be | output | 8 | Per-byte enables |
| busy | output | 1 | Flush in progress |

## Verification
The checker assumes that a commit is the only thing that raises busy, and that the caller does not raise the address load and the byte strobe in the same cycle. The bench drives one control input per cycle through tasks, so these assumptions always hold. Stimulus during busy is sent only on purpose, to show that it is ignored. The spacing check assumes `WCYC` is at least 1, and the bench uses a short value of 5 so that all eight page cycles finish quickly.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_ISSUE = 2'd1,
        FL_WAIT  = 2'd2
    } flush_st_t;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/wcache_store.sv
module wcache_store #(
    parameter int LINE_BYTES = 8,
    parameter int NUM_LINES  = 8,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = $clog2(NUM_LINES),
    localparam int DEPTH  = LINE_BYTES * NUM_LINES,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld,
    input  logic [OFF_W-1:0]        ld_off,
    input  logic                    stb,
    input  wcache_pkg::byte_t       din,
    input  logic                    clr,
    input  logic [LINE_W-1:0]       rd_line,
    output logic [LINE_BYTES*8-1:0] line_data,
    output logic [LINE_BYTES-1:0]   line_be,
    output logic                    any_valid
);
    wcache_pkg::byte_t mem [DEPTH];
    logic [DEPTH-1:0]  valid;
    logic [IDX_W-1:0]  ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            valid <= '0;
        end else begin
            if (ld) begin
                ptr <= IDX_W'(ld_off);
            end else if (stb) begin
                valid[ptr] <= 1'b1;
                ptr        <= ptr + 1'b1;
            end
            if (clr) valid <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!ld && stb) mem[ptr] <= din;
    end

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_slot
        assign line_data[b*8 +: 8] = mem[{rd_line, OFF_W'(b)}];
        assign line_be[b]          = valid[{rd_line, OFF_W'(b)}];
    end

    assign any_valid = |valid;
endmodule

// File: rtl/wcache_flush.sv
module wcache_flush #(
    parameter int NUM_LINES = 8,
    parameter int WCYC      = 200000,
    localparam int LINE_W = $clog2(NUM_LINES),
    localparam int CNT_W  = $clog2(WCYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              any_valid,
    input  logic              line_has,
    output logic [LINE_W-1:0] line,
    output logic              we,
    output logic              busy,
    output logic              clr
);
    import wcache_pkg::*;

    localparam logic [LINE_W-1:0] LAST = LINE_W'(NUM_LINES - 1);

    flush_st_t        st;
    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last = (line == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= FL_IDLE;
            line <= '0;
            cnt  <= '0;
        end else begin
            case (st)
                FL_IDLE: begin
                    line <= '0;
                    if (go && any_valid) st <= FL_ISSUE;
                end
                FL_ISSUE: begin
                    if (line_has) begin
                        st  <= FL_WAIT;
                        cnt <= CNT_W'(WCYC - 1);
                    end else if (at_last) begin
                        st <= FL_IDLE;
                    end else begin
                        line <= line + 1'b1;
                    end
                end
                FL_WAIT: begin
                    if (cnt == '0) begin
                        if (at_last) begin
                            st <= FL_IDLE;
                        end else begin
                            st   <= FL_ISSUE;
                            line <= line + 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= FL_IDLE;
            endcase
        end
    end

    assign we   = (st == FL_ISSUE) && line_has;
    assign busy = (st != FL_IDLE);
    assign clr  = at_last && (((st == FL_ISSUE) && !line_has) ||
                              ((st == FL_WAIT) && (cnt == '0)));
endmodule

// File: rtl/wcache_top.sv
module wcache_top #(
    parameter int ADDR_W        = 13,
    parameter int LINE_BYTES    = 8,
    parameter int NUM_LINES     = 8,
    parameter int PAGES_PER_ROW = 8,
    parameter int WCYC          = 200000,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int PG_W   = $clog2(PAGES_PER_ROW),
    localparam int PN_W   = ADDR_W - OFF_W,
    localparam int ROW_W  = PN_W - PG_W,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    addr_ld,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    wr_stb,
    input  logic [7:0]              wr_data,
    input  logic                    commit,
    output logic                    pg_we,
    output logic [ROW_W-1:0]        pg_row,
    output logic [PG_W-1:0]         pg_page,
    output logic [LINE_BYTES*8-1:0] pg_data,
    output logic [LINE_BYTES-1:0]   pg_be,
    output logic                    busy
);
    logic [PN_W-1:0]   base_pg;
    logic [PN_W-1:0]   tgt_pg;
    logic [LINE_W-1:0] cur_line;
    logic              any_valid;
    logic              clr;
    logic              ld_ok;
    logic              stb_ok;

    assign ld_ok  = addr_ld && !busy;
    assign stb_ok = wr_stb && !busy;

    always_ff @(posedge clk) begin
        if (rst)        base_pg <= '0;
        else if (ld_ok) base_pg <= addr_in[ADDR_W-1:OFF_W];
    end

    wcache_store #(.LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)) u_store (
        .clk(clk), .rst(rst),
        .ld(ld_ok), .ld_off(addr_in[OFF_W-1:0]),
        .stb(stb_ok), .din(wr_data),
        .clr(clr), .rd_line(cur_line),
        .line_data(pg_data), .line_be(pg_be), .any_valid(any_valid)
    );

    wcache_flush #(.NUM_LINES(NUM_LINES), .WCYC(WCYC)) u_flush (
        .clk(clk), .rst(rst),
        .go(commit && !busy), .any_valid(any_valid),
        .line_has(|pg_be), .line(cur_line),
        .we(pg_we), .busy(busy), .clr(clr)
    );

    assign tgt_pg  = base_pg + PN_W'(cur_line);
    assign pg_row  = tgt_pg[PN_W-1:PG_W];
    assign pg_page = tgt_pg[PG_W-1:0];
endmodule

// File: rtl/wcache_chk.sv
module wcache_chk #(
    parameter int WCYC       = 200000,
    parameter int LINE_BYTES = 8,
    localparam int GAP_W = $clog2(WCYC + 3) + 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  commit,
    input logic                  pg_we,
    input logic [LINE_BYTES-1:0] pg_be,
    input logic                  busy
);
    logic [GAP_W-1:0] gap;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (pg_we) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else if (gap != {GAP_W{1'b1}}) begin
            gap <= gap + 1'b1;
        end
    end

    // R7: a page strobe only happens inside a busy window
    a_r7_we_in_busy: assert property (@(posedge clk) disable iff (rst)
        pg_we |-> busy);

    // R7: successive page strobes are separated by the write cycle
    a_r7_gap: assert property (@(posedge clk) disable iff (rst)
        (pg_we && seen) |-> (gap >= GAP_W'(WCYC + 1)));

    // R6, R10: every page strobe carries at least one enabled byte
    a_r10_no_empty_write: assert property (@(posedge clk) disable iff (rst)
        pg_we |-> (pg_be != '0));

    // R9: busy rises only in response to a commit
    a_r9_busy_from_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));

    // R7: page strobe is a single-cycle pulse
    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        pg_we |=> !pg_we);
endmodule

bind wcache_top wcache_chk #(.WCYC(WCYC), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk(clk), .rst(rst), .commit(commit),
    .pg_we(pg_we), .pg_be(pg_be), .busy(busy)
);

// File: tb/wcache_top_test.sv
module wcache_top_test;
    localparam int WC = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_ld;
    logic [12:0] addr_in;
    logic        wr_stb;
    logic [7:0]  wr_data;
    logic        commit;
    logic        pg_we;
    logic [6:0]  pg_row;
    logic [2:0]  pg_page;
    logic [63:0] pg_data;
    logic [7:0]  pg_be;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    logic [6:0]  rec_row  [16];
    logic [2:0]  rec_page [16];
    logic [63:0] rec_data [16];
    logic [7:0]  rec_be   [16];
    int          rec_cyc  [16];
    int          nw = 0;
    int          busy_cnt = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    wcache_top #(.WCYC(WC)) uut (
        .clk(clk), .rst(rst), .addr_ld(addr_ld), .addr_in(addr_in),
        .wr_stb(wr_stb), .wr_data(wr_data), .commit(commit),
        .pg_we(pg_we), .pg_row(pg_row), .pg_page(pg_page),
        .pg_data(pg_data), .pg_be(pg_be), .busy(busy)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && busy) busy_cnt <= busy_cnt + 1;
        if (!rst && pg_we && nw < 16) begin
            rec_row[nw]  <= pg_row;
            rec_page[nw] <= pg_page;
            rec_data[nw] <= pg_data;
            rec_be[nw]   <= pg_be;
            rec_cyc[nw]  <= cyc;
            nw <= nw + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr_rec();
        @(negedge clk);
        nw = 0;
        busy_cnt = 0;
    endtask

    task automatic do_load(input logic [12:0] a);
        @(posedge clk); #1;
        addr_ld = 1'b1; addr_in = a;
        @(posedge clk); #1;
        addr_ld = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic do_commit();
        @(posedge clk); #1;
        commit = 1'b1;
        @(posedge clk); #1;
        commit = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 pg_we", pg_we, 0);
        clr_rec();
        do_commit();
        repeat (4) @(negedge clk);
        check("R1 no valid after reset", nw, 0);
    endtask

    task automatic t_single();
        clr_rec();
        do_load(13'h0155);
        do_byte(8'hA0); do_byte(8'hA1); do_byte(8'hA2);
        do_commit();
        wait_idle();
        check("R10 one write only", nw, 1);
        check("R2 row", rec_row[0], 5);
        check("R2 page", rec_page[0], 2);
        check("R6 be", rec_be[0], 8'hE0);
        check("R2 data", rec_data[0][63:40], 24'hA2A1A0);
    endtask

    task automatic t_cross();
        clr_rec();
        do_load(13'h00FE);
        do_byte(8'hB0); do_byte(8'hB1); do_byte(8'hB2); do_byte(8'hB3);
        do_commit();
        wait_idle();
        check("R3 two writes", nw, 2);
        check("R4 first row", rec_row[0], 3);
        check("R4 first page", rec_page[0], 7);
        check("R3 first be", rec_be[0], 8'hC0);
        check("R3 first data", rec_data[0][63:48], 16'hB1B0);
        check("R4 second row", rec_row[1], 4);
        check("R4 second page", rec_page[1], 0);
        check("R3 second be", rec_be[1], 8'h03);
        check("R3 second data", rec_data[1][15:0], 16'hB3B2);
        check("R7 gap", rec_cyc[1] - rec_cyc[0], WC + 1);
    endtask

    task automatic t_full();
        clr_rec();
        do_load(13'h0000);
        for (int i = 0; i < 66; i++) do_byte(8'(i));
        clr_rec();
        do_commit();
        wait_idle();
        check("R7 eight writes", nw, 8);
        check("R7 busy length", busy_cnt, 8 * (WC + 1));
        check("R5 overwrite slot0", rec_data[0][7:0], 64);
        check("R5 overwrite slot1", rec_data[0][15:8], 65);
        check("R5 kept slot2", rec_data[0][23:16], 2);
        check("R5 last line slot7", rec_data[7][63:56], 63);
        check("R4 last page", rec_page[7], 7);
        check("R6 full be", rec_be[3], 8'hFF);
    endtask

    task automatic t_empty();
        clr_rec();
        do_commit();
        repeat (6) @(negedge clk);
        check("R9 no write", nw, 0);
        check("R6 valid cleared, R9 busy low", busy_cnt, 0);
    endtask

    task automatic t_busy_ignore();
        clr_rec();
        do_load(13'h0040);
        do_byte(8'h11);
        do_commit();
        do_byte(8'h99);
        do_load(13'h1FF8);
        do_commit();
        wait_idle();
        check("R8 one write", nw, 1);
        check("R8 be", rec_be[0], 8'h01);
        check("R8 row", rec_row[0], 1);
        check("R8 data", rec_data[0][7:0], 8'h11);
        clr_rec();
        do_commit();
        repeat (6) @(negedge clk);
        check("R8 ignored byte not cached", nw, 0);
        clr_rec();
        do_byte(8'h22);
        do_commit();
        wait_idle();
        check("R8 ignored load kept old base row", rec_row[0], 1);
        check("R8 ignored load kept old base page", rec_page[0], 0);
        check("R8 slot after ignored load", rec_be[0], 8'h02);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; addr_ld = 1'b0; addr_in = '0;
        wr_stb = 1'b0; wr_data = '0; commit = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_single();
        t_cross();
        t_full();
        t_empty();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule